// File: doc/BRIEF.md
# Static Backward-Taken Branch Predictor with Redirect and Flush Control

This block sits beside the decode stage of a five-stage, in-order, single-issue pipeline whose instruction set has one architectural delay slot. When a conditional branch reaches decode, the block looks at where its target lies relative to the branch's own address. A target at or below that address is treated as a loop back-edge and predicted taken. A target above it is predicted not-taken. Unconditional jumps skip the prediction step and always redirect. A taken prediction redirects fetch in the following cycle and kills the instruction fetched behind the delay slot.

The branch then moves to execute, where the condition logic supplies the real outcome. The block compares that outcome with the direction it chose. On a mismatch it kills the two wrong-path instructions, the one in fetch and the one in decode, and steers fetch to the correct address. That address is the branch target if the branch turns out taken, and the fall-through address (branch address plus two instruction widths) if it does not. The delay-slot instruction is never killed on any outcome, so existing delay-slot code runs unchanged.

Two counters, one for resolved conditional branches and one for mispredictions, let the prediction quality be measured. Target computation, condition evaluation and the instruction cache are outside the block.

Top module: `bpred_static_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `fetchRedirect`, `killIf` and `killId` low and both counters at zero, and all in-flight branch tracking is cleared.
- R2: A conditional branch accepted in decode whose target is below its own address gives, in the next cycle, `fetchRedirect`=1, `fetchTarget` equal to the target, `killIf`=1 and `killId`=0.
- R3: A conditional branch whose target equals its own address is predicted taken, with the same next-cycle response as R2.
- R4: A conditional branch whose target is above its own address is predicted not-taken: no redirect and no kill in the next cycle.
- R5: An unconditional jump (`idIsJump`=1) accepted in decode always redirects to its target in the next cycle with `killIf`=1. `exTaken` has no effect on it, it never mispredicts and it is not counted.
- R6: A branch predicted taken that resolves not-taken (`exTaken`=0 in the cycle after decode) gives, one cycle later, `fetchRedirect`=1, `fetchTarget` equal to the branch address plus 2*INSN_BYTES, and `killIf`=`killId`=1.
- R7: A branch predicted not-taken that resolves taken (`exTaken`=1 in the cycle after decode) gives, one cycle later, `fetchRedirect`=1, `fetchTarget` equal to the branch target, and `killIf`=`killId`=1.
- R8: A branch whose resolved outcome matches its prediction produces no redirect and no kill in the cycle after it resolves.
- R9: The delay slot is preserved. `killId` is never high while the delay-slot instruction is in decode, and a branch or jump presented in decode in the cycle right after an accepted branch is ignored.
- R10: A branch or jump presented in decode in a cycle where `killId` is high is ignored: no prediction, no tracking and no counting.
- R11: `resolvedCount` rises by one for each conditional branch resolved and `mispredictCount` by one for each mismatch. Both are visible two cycles after the branch was in decode.
- R12: A branch or jump presented with `idValid`=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idValid | input | 1 | Decode stage holds a valid instruction |
| idIsBranch | input | 1 | Decode instruction is a conditional branch |
| idIsJump | input | 1 | Decode instruction is an unconditional jump |
| idPc | input | AW | Address of the decode instruction |
| idTarget | input | AW | Branch or jump target of the decode instruction |
| exTaken | input | 1 | Resolved outcome of the branch currently in execute |
| fetchRedirect | output | 1 | Fetch must continue at `fetchTarget` |
| fetchTarget | output | AW | Redirect address |
| killIf | output | 1 | Invalidate the instruction now in fetch |
| killId | output | 1 | Invalidate the instruction now in decode |
| resolvedCount | output | CW | Resolved conditional branches |
| mispredictCount | output | CW | Mispredicted conditional branches |

## Verification
A prediction shows on the outputs one cycle after the branch is in decode. A correction and the counter updates show two cycles after decode, because they depend on `exTaken` driven in the cycle between. The bench drives each cycle's inputs on the falling edge. Its behavioural model then files the expected outputs under the number of the cycle in which they must appear. On the next falling edge the bench compares the outputs with that cycle's slot, so every result is read exactly on the cycle it is due, never earlier or later.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  // Strobes from the control path to the datapath, one cycle's worth.
  typedef struct packed {
    logic capture;       // latch branch addresses for execute
    logic loadPred;      // load decode target as redirect address
    logic loadFix;       // load correction address as redirect address
    logic fixToTarget;   // correction goes to target (else fall-through)
    logic countResolve;  // a conditional branch resolved this cycle
    logic countMiss;     // it was mispredicted
  } bpStrobe_t;

endpackage

// File: rtl/bpred_datapath.sv
module bpred_datapath
  import bpred_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  bpStrobe_t     strobe,
  input  logic [AW-1:0] idPc,
  input  logic [AW-1:0] idTarget,
  output logic          isBackward,
  output logic [AW-1:0] fetchTarget,
  output logic [CW-1:0] resolvedCount,
  output logic [CW-1:0] mispredictCount
);

  localparam logic [AW-1:0] FALL_OFS = AW'(2 * INSN_BYTES);

  logic [AW-1:0] exTarget;
  logic [AW-1:0] exFall;
  logic [AW-1:0] fixAddr;

  // Equal address counts as backward: tight self-loops predict taken.
  assign isBackward = (idTarget <= idPc);
  assign fixAddr    = strobe.fixToTarget ? exTarget : exFall;

  always_ff @(posedge clk) begin
    if (rst) begin
      exTarget <= '0;
      exFall   <= '0;
    end else if (strobe.capture) begin
      exTarget <= idTarget;
      exFall   <= idPc + FALL_OFS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchTarget <= '0;
    end else if (strobe.loadFix) begin
      fetchTarget <= fixAddr;
    end else if (strobe.loadPred) begin
      fetchTarget <= idTarget;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resolvedCount   <= '0;
      mispredictCount <= '0;
    end else begin
      if (strobe.countResolve) resolvedCount <= resolvedCount + CW'(1);
      if (strobe.countMiss)    mispredictCount <= mispredictCount + CW'(1);
    end
  end

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe.countMiss |=> (mispredictCount == $past(mispredictCount) + CW'(1))); // R11
  AST_RESOLVE_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobe.countResolve && !strobe.countMiss) |=> $stable(mispredictCount)); // R8

endmodule

// File: rtl/bpred_control.sv
module bpred_control
  import bpred_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      idValid,
  input  logic      idIsBranch,
  input  logic      idIsJump,
  input  logic      isBackward,
  input  logic      exTaken,
  output bpStrobe_t strobe,
  output logic      fetchRedirect,
  output logic      killIf,
  output logic      killId
);

  logic exValid;
  logic exIsJump;
  logic exPredTaken;
  logic dsShadow;     // delay-slot instruction sits in decode this cycle
  logic decodeHit;
  logic predTake;
  logic mispredict;

  assign decodeHit  = idValid && (idIsBranch || idIsJump) && !killId && !dsShadow;
  assign predTake   = idIsJump || isBackward;
  assign mispredict = exValid && !exIsJump && (exTaken != exPredTaken);

  always_comb begin
    strobe              = '0;
    strobe.capture      = decodeHit;
    strobe.loadPred     = decodeHit && predTake;
    strobe.loadFix      = mispredict;
    strobe.fixToTarget  = exTaken;
    strobe.countResolve = exValid && !exIsJump;
    strobe.countMiss    = mispredict;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exValid       <= 1'b0;
      exIsJump      <= 1'b0;
      exPredTaken   <= 1'b0;
      dsShadow      <= 1'b0;
      fetchRedirect <= 1'b0;
      killIf        <= 1'b0;
      killId        <= 1'b0;
    end else begin
      exValid       <= decodeHit;
      exIsJump      <= idIsJump;
      exPredTaken   <= predTake;
      dsShadow      <= decodeHit;
      fetchRedirect <= (decodeHit && predTake) || mispredict;
      killIf        <= (decodeHit && predTake) || mispredict;
      killId        <= mispredict;
    end
  end

  AST_DS_KEPT: assert property (@(posedge clk) disable iff (rst)
    dsShadow |-> !killId); // R9
  AST_FIX_AFTER_EX: assert property (@(posedge clk) disable iff (rst)
    killId |-> ($past(exValid) && !$past(exIsJump))); // R7
  AST_FIX_REDIRECTS: assert property (@(posedge clk) disable iff (rst)
    killId |-> (fetchRedirect && killIf)); // R6
  AST_PRED_FROM_DECODE: assert property (@(posedge clk) disable iff (rst)
    (fetchRedirect && !killId) |-> $past(decodeHit && predTake)); // R2
  AST_NO_DS_DECODE: assert property (@(posedge clk) disable iff (rst)
    dsShadow |=> !dsShadow); // R9

endmodule

// File: rtl/bpred_static_top.sv
module bpred_static_top
  import bpred_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idValid,
  input  logic          idIsBranch,
  input  logic          idIsJump,
  input  logic [AW-1:0] idPc,
  input  logic [AW-1:0] idTarget,
  input  logic          exTaken,
  output logic          fetchRedirect,
  output logic [AW-1:0] fetchTarget,
  output logic          killIf,
  output logic          killId,
  output logic [CW-1:0] resolvedCount,
  output logic [CW-1:0] mispredictCount
);

  bpStrobe_t strobe;
  logic      isBackward;

  bpred_control u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .idValid      (idValid),
    .idIsBranch   (idIsBranch),
    .idIsJump     (idIsJump),
    .isBackward   (isBackward),
    .exTaken      (exTaken),
    .strobe       (strobe),
    .fetchRedirect(fetchRedirect),
    .killIf       (killIf),
    .killId       (killId)
  );

  bpred_datapath #(
    .AW        (AW),
    .CW        (CW),
    .INSN_BYTES(INSN_BYTES)
  ) u_dp (
    .clk            (clk),
    .rst            (rst),
    .strobe         (strobe),
    .idPc           (idPc),
    .idTarget       (idTarget),
    .isBackward     (isBackward),
    .fetchTarget    (fetchTarget),
    .resolvedCount  (resolvedCount),
    .mispredictCount(mispredictCount)
  );

endmodule

// File: tb/sim_bpred_static_top.sv
module sim_bpred_static_top;

  localparam int AW = 32;
  localparam int CW = 16;
  localparam int MAXC = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idValid = 1'b0, idIsBranch = 1'b0, idIsJump = 1'b0, exTaken = 1'b0;
  logic [AW-1:0] idPc = '0, idTarget = '0;
  logic fetchRedirect, killIf, killId;
  logic [AW-1:0] fetchTarget;
  logic [CW-1:0] resolvedCount, mispredictCount;

  always #2 clk = ~clk;

  bpred_static_top #(.AW(AW), .CW(CW), .INSN_BYTES(4)) u0 (
    .clk(clk), .rst(rst), .idValid(idValid), .idIsBranch(idIsBranch),
    .idIsJump(idIsJump), .idPc(idPc), .idTarget(idTarget), .exTaken(exTaken),
    .fetchRedirect(fetchRedirect), .fetchTarget(fetchTarget), .killIf(killIf),
    .killId(killId), .resolvedCount(resolvedCount), .mispredictCount(mispredictCount)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // Expected outputs, filed by the cycle they are due in.
  bit eRed [MAXC];
  bit eKif [MAXC];
  bit eKid [MAXC];
  logic [AW-1:0] eTgt [MAXC];
  int eRes [MAXC];
  int eMis [MAXC];
  string eTag [MAXC];

  // Model state
  int lastAcc = -10;
  bit pendV = 0, pendJmp = 0, pendPred = 0;
  logic [AW-1:0] pendPc = '0, pendTgt = '0;
  int resCnt = 0, misCnt = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic step(bit r, bit v, bit br, bit jp, logic [AW-1:0] pc,
                      logic [AW-1:0] tgt, bit tk);
    int n;
    bit killNow;
    @(negedge clk);
    if (cyc > 0) begin
      chk(eTag[cyc], "fetchRedirect", 64'(fetchRedirect), 64'(eRed[cyc]));
      if (eRed[cyc]) chk(eTag[cyc], "fetchTarget", 64'(fetchTarget), 64'(eTgt[cyc]));
      chk(eTag[cyc], "killIf", 64'(killIf), 64'(eKif[cyc]));
      chk(eTag[cyc], "killId", 64'(killId), 64'(eKid[cyc]));
      chk(eTag[cyc] == "R1" ? "R1" : "R11", "resolvedCount", 64'(resolvedCount), 64'(eRes[cyc]));
      chk(eTag[cyc] == "R1" ? "R1" : "R11", "mispredictCount", 64'(mispredictCount), 64'(eMis[cyc]));
    end
    rst = r; idValid = v; idIsBranch = br; idIsJump = jp;
    idPc = pc; idTarget = tgt; exTaken = tk;
    n = cyc + 1;
    eRed[n] = 0; eKif[n] = 0; eKid[n] = 0; eTgt[n] = '0; eTag[n] = "R8";
    if (r) begin
      lastAcc = -10; pendV = 0; resCnt = 0; misCnt = 0;
      eTag[n] = "R1";
    end else begin
      killNow = eKid[cyc];
      if (pendV && !pendJmp) begin
        resCnt++;
        if (tk != pendPred) begin
          misCnt++;
          eRed[n] = 1; eKif[n] = 1; eKid[n] = 1;
          eTgt[n] = tk ? pendTgt : pendPc + 32'd8;
          eTag[n] = tk ? "R7" : "R6";
        end
      end
      pendV = 0;
      if (v && (br || jp)) begin
        if (killNow) begin
          if (!eRed[n]) eTag[n] = "R10";
        end else if (lastAcc == cyc - 1) begin
          if (!eRed[n]) eTag[n] = "R9";
        end else begin
          lastAcc = cyc; pendV = 1; pendJmp = jp;
          pendPred = jp || (tgt <= pc);
          pendPc = pc; pendTgt = tgt;
          if (pendPred) begin
            eRed[n] = 1; eKif[n] = 1; eTgt[n] = tgt;
            eTag[n] = jp ? "R5" : ((tgt == pc) ? "R3" : "R2");
          end else begin
            eTag[n] = "R4";
          end
        end
      end else if (!v && (br || jp)) begin
        eTag[n] = "R12";
      end
    end
    eRes[n] = resCnt; eMis[n] = misCnt;
    cyc++;
  endtask

  task automatic idle(bit tk);
    step(0, 1, 0, 0, 32'h0, 32'h0, tk);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    // R1: reset
    step(1, 1, 1, 0, 32'h100, 32'h80, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    idle(0);
    // R2 backward, resolved taken (R8 correct)
    step(0, 1, 1, 0, 32'h1000, 32'h0f00, 0);
    idle(1); idle(0); idle(0);
    // R6 backward resolved not-taken
    step(0, 1, 1, 0, 32'h2000, 32'h1f00, 0);
    idle(0); idle(0); idle(0);
    // R4 forward correct, R7 forward taken
    step(0, 1, 1, 0, 32'h3000, 32'h3100, 0);
    idle(0); idle(0);
    step(0, 1, 1, 0, 32'h4000, 32'h4100, 0);
    idle(1); idle(0); idle(0);
    // R3 self loop
    step(0, 1, 1, 0, 32'h5000, 32'h5000, 0);
    idle(1); idle(0);
    // R5 jump forward, exTaken ignored
    step(0, 1, 0, 1, 32'h6000, 32'h7000, 0);
    idle(0); idle(1); idle(0);
    // R9 branch in delay slot is ignored
    step(0, 1, 1, 0, 32'h8000, 32'h9000, 0);
    step(0, 1, 1, 0, 32'h8004, 32'h7000, 0);
    idle(0); idle(0);
    // R10 branch in killed decode slot ignored
    step(0, 1, 1, 0, 32'ha000, 32'hb000, 0);
    idle(1);
    step(0, 1, 1, 0, 32'ha008, 32'h9000, 0);
    idle(0); idle(0); idle(0);
    // R12 invalid decode ignored
    step(0, 0, 1, 0, 32'hc000, 32'hb000, 0);
    step(0, 0, 0, 1, 32'hc004, 32'hd000, 0);
    idle(0); idle(0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pc, tgt;
      int sel;
      pc = {$urandom_range(0, 32'h3fff_fff0), 2'b00};
      sel = $urandom_range(0, 9);
      if (sel < 4) tgt = pc - {$urandom_range(1, 4096), 2'b00};
      else if (sel < 8) tgt = pc + {$urandom_range(1, 4096), 2'b00};
      else tgt = pc;
      step(($urandom_range(0, 199) == 0), ($urandom_range(0, 9) != 0),
           ($urandom_range(0, 9) < 4), ($urandom_range(0, 9) == 0),
           pc, tgt, 1'($urandom_range(0, 1)));
    end
    idle(0); idle(0); idle(0);
    summary();
  end

endmodule